// File: doc/BRIEF.md
# Indexed Real-Time Clock

This block is a byte-wide calendar clock that software reaches through two ports: an index port and a data port. Writing the index port picks one internal register with its low seven bits. The top bit of that same byte is held as a mask for the non-maskable interrupt and is driven out on a pin. Later data-port reads and writes go to the chosen register. Reading the index port gives back the whole byte last written to it, so software can change the mask bit with a read-modify-write.

A divider counts single-cycle time-base enable pulses, which arrive at 32.768 kHz in normal use. Once per second it advances the seconds, minutes, hours, day, month and two-digit year fields. It can count in BCD or in binary, and in 24-hour or 12-hour form. For a short window before each advance, a status bit warns that an update is coming. A free-running counter driven by the same pulses produces a periodic event at a power-of-two rate. Three event flags (periodic, alarm and update-ended) are gated by enables onto one interrupt line. Reading the flag register clears the flags.

Top module: `rtc_indexed`

## Requirements
- R1: A write with `sel_data`=0 loads the index byte. Bits [6:0] select the register for later data accesses. A read with `sel_data`=0 returns the full byte. `nmi_mask` equals bit 7 of the byte last written.
- R2: The time registers (seconds 0x00, minutes 0x02, hours 0x04, day 0x07, month 0x08, year 0x09) and the alarm registers (seconds 0x01, minutes 0x03, hours 0x05) store data-port writes as written and read them back. Unmapped indexes read 0x00, and writes to them have no effect.
- R3: Each TICKS_PER_SEC time-base pulses, the time advances by one second. When control register B (0x0B) bit 2 is 0, fields count in BCD (for example seconds 0x09→0x10, and 0x59→0x00 with a carry into minutes).
- R4: When B bit 2 is 1, fields count in plain binary (seconds 9→10 reads 0x0A; 59→0 carries).
- R5: When B bit 1 is 1, hours run 0..23. When B bit 1 is 0, hours run 1..12 with bit 7 meaning PM: 11 AM→12 PM (0x92), 12 PM→1 PM (0x81), 11 PM→12 AM (0x12) with a day carry, and 12 AM→1 AM (0x01).
- R6: After the last day of a month, the day returns to 1 and the month advances. April, June, September and November have 30 days. February has 29 days when the year is divisible by 4 and 28 otherwise. December 31 goes to January 1, and year 99 goes to 0.
- R7: Register A (0x0A) bit 7 reads 1 during the last UIP_TICKS time-base periods before an advance, and 0 otherwise. Bits [6:0] are writable.
- R8: With rate r = A[3:0] in 3..15, the periodic flag (register C bit 6) is set once every 2^(r-1) time-base pulses, on the pulse where the pulse count since reset, taken modulo 2^(r-1), equals 2^(r-1)-1. Rates 0, 1 and 2 produce no periodic events.
- R9: After an advance, if the new seconds, minutes and hours match the alarm registers, the alarm flag (C bit 5) is set.
- R10: Every advance sets the update-ended flag (C bit 4).
- R11: Register C (0x0C) reads the flags in bits [6:4]. Bit 7 is 1 when any flag is set together with its enable in B (bit 6 periodic, bit 5 alarm, bit 4 update). `irq` follows bit 7. A data-port read of C clears the flags, but an event in the same cycle still sets its flag.
- R12: After reset, the index is 0x00, the time is 00:00:00 day 1 month 1 year 0, A is 0x20, B is 0x02, the flags are clear, and `irq` and `nmi_mask` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| timebase_en | input | 1 | One-cycle pulse per 32.768 kHz period |
| sel_data | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle (clears the flags when reading C) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected port, combinational |
| nmi_mask | output | 1 | Bit 7 of the index byte |
| irq | output | 1 | Enabled pending interrupt |

## Verification
The rollovers of the month, the leap-year February and the end of the century would take days or years of ticks to reach naturally. The bench shortens the second to 16 pulses. It then writes every time field to one second before the boundary and issues exactly one second of pulses, so each calendar edge and each 12-hour transition is crossed in isolation. The phase of the periodic event is reached by keeping every earlier step a multiple of 16 pulses. The bench therefore knows the free-running count modulo the period, and steps it one pulse short of the event and then onto it.

// File: rtl/rtc_indexed.sv
module rtc_indexed #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       timebase_en,
  input  logic       sel_data,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       nmi_mask,
  output logic       irq
);
  localparam int DW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [DW-1:0] LAST      = DW'(TICKS_PER_SEC - 1);
  localparam logic [DW-1:0] UIP_START = DW'(TICKS_PER_SEC - UIP_TICKS);
  localparam logic [6:0] X_SEC = 7'h00, X_ASEC = 7'h01, X_MIN = 7'h02, X_AMIN = 7'h03,
                         X_HR  = 7'h04, X_AHR  = 7'h05, X_DAY = 7'h07, X_MON  = 7'h08,
                         X_YR  = 7'h09, X_A    = 7'h0A, X_B   = 7'h0B, X_C    = 7'h0C;

  logic [7:0]    idx, sec, min, hr, day, mon, yr, asec, amin, ahr, ctl_b;
  logic [6:0]    ctl_a;
  logic [2:0]    flg;
  logic [DW-1:0] dc;
  logic [14:0]   pcnt, pmask;
  logic [7:0]    n_sec, n_min, n_hr, n_day, n_mon, n_yr;
  logic          alarm_hit;

  function automatic logic [6:0] f2b(input logic [7:0] v, input logic bin);
    return bin ? v[6:0] : ({3'b0, v[7:4]} * 7'd10 + {3'b0, v[3:0]});
  endfunction

  function automatic logic [7:0] b2f(input logic [6:0] n, input logic bin);
    return bin ? {1'b0, n} : ({1'b0, n} + 8'd6 * {1'b0, n / 7'd10});
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] m, input logic [1:0] ylo);
    case (m)
      7'd2:                        return (ylo == 2'd0) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:     return 7'd30;
      default:                     return 7'd31;
    endcase
  endfunction

  wire bin_m  = ctl_b[2];
  wire h24_m  = ctl_b[1];
  wire roll   = timebase_en && (dc == LAST);
  wire uip    = (dc >= UIP_START);
  wire c_read = rd_en && sel_data && (idx[6:0] == X_C);
  wire [3:0] rate = ctl_a[3:0];
  assign pmask = (15'd1 << (rate - 4'd1)) - 15'd1;
  wire per_evt = timebase_en && (rate >= 4'd3) && ((pcnt & pmask) == pmask);
  wire irq_any = |(flg & ctl_b[6:4]);

  assign nmi_mask = idx[7];
  assign irq      = irq_any;

  always_comb begin
    logic [6:0] s, m, h, d, mo, y, hb, h12;
    s  = f2b(sec, bin_m);
    m  = f2b(min, bin_m);
    d  = f2b(day, bin_m);
    mo = f2b(mon, bin_m);
    y  = f2b(yr, bin_m);
    hb = f2b({1'b0, hr[6:0]}, bin_m);
    if (h24_m)               h = hb;
    else if (hb == 7'd12)    h = hr[7] ? 7'd12 : 7'd0;
    else                     h = hr[7] ? hb + 7'd12 : hb;
    s = s + 7'd1;
    if (s == 7'd60) begin
      s = 7'd0; m = m + 7'd1;
      if (m == 7'd60) begin
        m = 7'd0; h = h + 7'd1;
        if (h == 7'd24) begin
          h = 7'd0; d = d + 7'd1;
          if (d > month_len(mo, y[1:0])) begin
            d = 7'd1; mo = mo + 7'd1;
            if (mo == 7'd13) begin
              mo = 7'd1; y = y + 7'd1;
              if (y == 7'd100) y = 7'd0;
            end
          end
        end
      end
    end
    h12   = (h == 7'd0) ? 7'd12 : (h > 7'd12) ? h - 7'd12 : h;
    n_sec = b2f(s, bin_m);
    n_min = b2f(m, bin_m);
    n_hr  = h24_m ? b2f(h, bin_m) : (b2f(h12, bin_m) | {h >= 7'd12, 7'd0});
    n_day = b2f(d, bin_m);
    n_mon = b2f(mo, bin_m);
    n_yr  = b2f(y, bin_m);
    alarm_hit = (n_sec == asec) && (n_min == amin) && (n_hr == ahr);
  end

  always_comb begin
    rdata = 8'h00;
    if (!sel_data) rdata = idx;
    else begin
      case (idx[6:0])
        X_SEC:  rdata = sec;
        X_ASEC: rdata = asec;
        X_MIN:  rdata = min;
        X_AMIN: rdata = amin;
        X_HR:   rdata = hr;
        X_AHR:  rdata = ahr;
        X_DAY:  rdata = day;
        X_MON:  rdata = mon;
        X_YR:   rdata = yr;
        X_A:    rdata = {uip, ctl_a};
        X_B:    rdata = ctl_b;
        X_C:    rdata = {irq_any, flg, 4'b0};
        default: rdata = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0; sec <= '0; min <= '0; hr <= '0; day <= 8'h01; mon <= 8'h01; yr <= '0;
      asec <= '0; amin <= '0; ahr <= '0;
      ctl_a <= 7'h20; ctl_b <= 8'h02; flg <= '0; dc <= '0; pcnt <= '0;
    end else begin
      if (timebase_en) begin
        dc   <= roll ? '0 : dc + 1'b1;
        pcnt <= pcnt + 15'd1;
      end
      if (roll) begin
        sec <= n_sec; min <= n_min; hr <= n_hr;
        day <= n_day; mon <= n_mon; yr <= n_yr;
      end
      flg <= (c_read ? 3'b000 : flg) | {per_evt, roll && alarm_hit, roll};
      if (wr_en && !sel_data) idx <= wdata;
      if (wr_en && sel_data) begin
        case (idx[6:0])
          X_SEC:  sec   <= wdata;
          X_ASEC: asec  <= wdata;
          X_MIN:  min   <= wdata;
          X_AMIN: amin  <= wdata;
          X_HR:   hr    <= wdata;
          X_AHR:  ahr   <= wdata;
          X_DAY:  day   <= wdata;
          X_MON:  mon   <= wdata;
          X_YR:   yr    <= wdata;
          X_A:    ctl_a <= wdata[6:0];
          X_B:    ctl_b <= wdata;
          default: ;
        endcase
      end
    end
  end

  // R1: the mask pin follows the top bit of the index byte just written
  a_r1_mask_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel_data) |=> (nmi_mask == $past(wdata[7])));

  // R3: seconds move only on an advance or a software write
  a_r3_sec_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!roll && !(wr_en && sel_data)) |=> $stable(sec));

  // R7: the update warning ends only through an advance
  a_r7_uip_ends_on_roll: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uip) |-> $past(roll));

  // R8: a periodic event always leaves its flag set
  a_r8_pf_set: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt |=> flg[2]);

  // R10: an advance always leaves the update-ended flag set
  a_r10_uf_set: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> flg[0]);

  // R11: reading the flag register with no new event drops the interrupt
  a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (c_read && !roll && !per_evt) |=> !irq);
endmodule

// File: tb/rtc_indexed_bench.sv
`timescale 1ns/1ps
module rtc_indexed_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, timebase_en = 1'b0, sel_data = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic nmi_mask, irq;

  rtc_indexed #(.TICKS_PER_SEC(16), .UIP_TICKS(2)) u_rtc_indexed (
    .clk(clk), .rst_n(rst_n), .timebase_en(timebase_en), .sel_data(sel_data),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .nmi_mask(nmi_mask), .irq(irq));

  int checks = 0, failures = 0;
  bit finished = 1'b0;
  logic [7:0] expq[$];
  string tagq[$];

  always @(negedge clk) begin
    if (rd_en) begin
      logic [7:0] e;
      string t;
      if (expq.size() == 0) begin
        checks++; failures++;
        $display("FAIL scoreboard empty actual=%02h expected=queued item", rdata);
      end else begin
        e = expq.pop_front();
        t = tagq.pop_front();
        if (t != "skip") begin
          checks++;
          if (rdata !== e) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", t, rdata, e);
          end
        end
      end
    end
  end

  task automatic cyc(); @(posedge clk); #1; endtask

  task automatic idx_wr(input logic [7:0] v);
    sel_data = 1'b0; wr_en = 1'b1; wdata = v; cyc(); wr_en = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] v);
    idx_wr(i);
    sel_data = 1'b1; wr_en = 1'b1; wdata = v; cyc(); wr_en = 1'b0;
  endtask

  task automatic rd_exp(input logic [7:0] i, input logic [7:0] e, input string tag);
    idx_wr(i);
    expq.push_back(e); tagq.push_back(tag);
    sel_data = 1'b1; rd_en = 1'b1; cyc(); rd_en = 1'b0;
  endtask

  task automatic idx_rd_exp(input logic [7:0] e, input string tag);
    expq.push_back(e); tagq.push_back(tag);
    sel_data = 1'b0; rd_en = 1'b1; cyc(); rd_en = 1'b0;
  endtask

  task automatic clr_c();
    rd_exp(8'h0C, 8'h00, "skip");
  endtask

  task automatic chk(input logic act, input logic e, input string tag);
    checks++;
    if (act !== e) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, e);
    end
  endtask

  task automatic tick_n(input int n);
    for (int k = 0; k < n; k++) begin
      timebase_en = 1'b1; cyc(); timebase_en = 1'b0; cyc();
    end
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                          input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y);
    reg_wr(8'h04, h); reg_wr(8'h02, m); reg_wr(8'h00, s);
    reg_wr(8'h07, d); reg_wr(8'h08, mo); reg_wr(8'h09, y);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #600000;
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R12 reset state
    idx_rd_exp(8'h00, "R12 index");
    chk(irq, 1'b0, "R12 irq");
    chk(nmi_mask, 1'b0, "R12 nmi_mask");
    rd_exp(8'h00, 8'h00, "R12 seconds");
    rd_exp(8'h07, 8'h01, "R12 day");
    rd_exp(8'h08, 8'h01, "R12 month");
    rd_exp(8'h0A, 8'h20, "R12 reg A");
    rd_exp(8'h0B, 8'h02, "R12 reg B");
    rd_exp(8'h0C, 8'h00, "R12 reg C");

    // R1 index byte and mask bit
    idx_wr(8'h8B);
    idx_rd_exp(8'h8B, "R1 index readback");
    chk(nmi_mask, 1'b1, "R1 mask set");
    rd_exp(8'h8B, 8'h02, "R1 select ignores bit 7");
    chk(nmi_mask, 1'b1, "R1 mask kept");
    idx_wr(8'h00);
    chk(nmi_mask, 1'b0, "R1 mask cleared");

    // R2 storage and unmapped index
    reg_wr(8'h02, 8'h45);
    rd_exp(8'h02, 8'h45, "R2 minutes readback");
    reg_wr(8'h03, 8'h17);
    rd_exp(8'h03, 8'h17, "R2 alarm minutes readback");
    reg_wr(8'h03, 8'h00);
    reg_wr(8'h0E, 8'h55);
    rd_exp(8'h0E, 8'h00, "R2 unmapped reads zero");

    // R7 update-in-progress window (16 pulses per second, 2-pulse window)
    tick_n(13);
    rd_exp(8'h0A, 8'h20, "R7 before window");
    tick_n(1);
    rd_exp(8'h0A, 8'hA0, "R7 inside window");
    tick_n(2);
    rd_exp(8'h0A, 8'h20, "R7 after advance");
    rd_exp(8'h00, 8'h01, "R3 one second elapsed");
    rd_exp(8'h02, 8'h45, "R3 minutes unchanged");
    rd_exp(8'h0C, 8'h10, "R10 update flag");
    rd_exp(8'h0C, 8'h00, "R11 cleared by read");

    // R3 BCD counting, R5 24-hour wrap, R6 year-end
    reg_wr(8'h00, 8'h09);
    tick_n(16);
    rd_exp(8'h00, 8'h10, "R3 BCD 09->10");
    set_time(8'h23, 8'h59, 8'h59, 8'h31, 8'h12, 8'h99);
    tick_n(16);
    rd_exp(8'h00, 8'h00, "R3 seconds wrap");
    rd_exp(8'h02, 8'h00, "R3 minutes wrap");
    rd_exp(8'h04, 8'h00, "R5 24h midnight");
    rd_exp(8'h07, 8'h01, "R6 day after Dec 31");
    rd_exp(8'h08, 8'h01, "R6 month after Dec");
    rd_exp(8'h09, 8'h00, "R6 year 99->00");

    // R6 month lengths and leap rule
    set_time(8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h24);
    tick_n(16);
    rd_exp(8'h07, 8'h29, "R6 leap Feb 29");
    rd_exp(8'h08, 8'h02, "R6 leap stays Feb");
    set_time(8'h23, 8'h59, 8'h59, 8'h29, 8'h02, 8'h24);
    tick_n(16);
    rd_exp(8'h07, 8'h01, "R6 leap Feb end day");
    rd_exp(8'h08, 8'h03, "R6 leap Feb end month");
    set_time(8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h23);
    tick_n(16);
    rd_exp(8'h08, 8'h03, "R6 common Feb 28 end");
    set_time(8'h23, 8'h59, 8'h59, 8'h30, 8'h04, 8'h23);
    tick_n(16);
    rd_exp(8'h07, 8'h01, "R6 April 30 end day");
    rd_exp(8'h08, 8'h05, "R6 April 30 end month");

    // R4 binary counting
    reg_wr(8'h0B, 8'h06);
    set_time(8'h00, 8'h00, 8'h09, 8'h01, 8'h01, 8'h00);
    tick_n(16);
    rd_exp(8'h00, 8'h0A, "R4 binary 9->10");
    set_time(8'h17, 8'h3B, 8'h3B, 8'h1E, 8'h04, 8'h05);
    tick_n(16);
    rd_exp(8'h00, 8'h00, "R4 binary seconds wrap");
    rd_exp(8'h04, 8'h00, "R4 binary hour wrap");
    rd_exp(8'h07, 8'h01, "R4 binary day wrap");
    rd_exp(8'h08, 8'h05, "R4 binary month");

    // R5 12-hour transitions (BCD)
    reg_wr(8'h0B, 8'h00);
    set_time(8'h11, 8'h59, 8'h59, 8'h05, 8'h05, 8'h10);
    tick_n(16);
    rd_exp(8'h04, 8'h92, "R5 11AM->12PM");
    set_time(8'h92, 8'h59, 8'h59, 8'h05, 8'h05, 8'h10);
    tick_n(16);
    rd_exp(8'h04, 8'h81, "R5 12PM->1PM");
    set_time(8'h91, 8'h59, 8'h59, 8'h05, 8'h05, 8'h10);
    tick_n(16);
    rd_exp(8'h04, 8'h12, "R5 11PM->12AM");
    rd_exp(8'h07, 8'h06, "R5 midnight day carry");
    set_time(8'h12, 8'h59, 8'h59, 8'h05, 8'h05, 8'h10);
    tick_n(16);
    rd_exp(8'h04, 8'h01, "R5 12AM->1AM");

    // R9 alarm, R10 update flag, R11 gating and clear
    reg_wr(8'h0B, 8'h22);
    reg_wr(8'h05, 8'h10); reg_wr(8'h03, 8'h00); reg_wr(8'h01, 8'h05);
    set_time(8'h10, 8'h00, 8'h04, 8'h05, 8'h05, 8'h10);
    clr_c();
    tick_n(16);
    chk(irq, 1'b1, "R11 irq on enabled alarm");
    rd_exp(8'h0C, 8'hB0, "R9 alarm match flags");
    chk(irq, 1'b0, "R11 irq dropped by read");
    rd_exp(8'h0C, 8'h00, "R11 flags cleared");
    tick_n(16);
    chk(irq, 1'b0, "R11 update flag not enabled");
    rd_exp(8'h0C, 8'h10, "R9 no alarm on mismatch");

    // R8 periodic rate; all pulses so far are a multiple of 16
    reg_wr(8'h0B, 8'h42);
    clr_c();
    reg_wr(8'h0A, 8'h23);
    tick_n(3);
    chk(irq, 1'b0, "R8 rate 3 before period");
    rd_exp(8'h0C, 8'h00, "R8 no flag yet");
    tick_n(1);
    chk(irq, 1'b1, "R8 irq at period");
    rd_exp(8'h0C, 8'hC0, "R8 periodic flag");
    reg_wr(8'h0A, 8'h20);
    tick_n(8);
    rd_exp(8'h0C, 8'h00, "R8 rate 0 silent");
    reg_wr(8'h0A, 8'h22);
    tick_n(4);
    chk(irq, 1'b0, "R8 rate 2 no irq");
    rd_exp(8'h0C, 8'h10, "R8 rate 2 silent, R10 update only");

    cyc();
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule